// File: doc/BRIEF.md
# Display Controller Byte Decoder

This block sits behind a two-wire serial slave front end that has already stripped the bus address and assembled whole bytes. Every byte the host sends arrives as a one-cycle `rx_valid` strobe with `rx_byte`, and the end of a bus transfer arrives as a one-cycle `rx_stop` strobe. The block sorts each byte into one of four kinds: a control byte that picks the mode, a command byte, a discarded command parameter, or a display data byte. Commands move a page/column write pointer and set the display mode flags. Data bytes land in a page-organised frame memory of 132 columns by 8 pages, one byte per cell.

A scan-out engine outside the block reads the frame memory through a second, independent read port. It watches `redraw` to learn that the picture has changed and clears it with `redraw_ack`. Host reads are not decoded. The read byte is tied to all ones.

The mode machine has three states: MODE_IDLE (waiting for a control byte), MODE_DATA (bytes go to memory) and MODE_CMD (bytes are commands). Alongside it sits a parameter-skip flag. The named transitions are:
- IDLE_TO_CMD on control byte 0x80.
- IDLE_TO_DATA on control byte 0x40.
- CMD_TO_IDLE after any executed command.
- CMD_HOLD when a byte is swallowed as a parameter.
- ANY_TO_IDLE on a stop strobe.

Top module: `oled_cmd_decoder`

## Requirements
- R1: In MODE_IDLE, byte 0x80 enters MODE_CMD and byte 0x40 enters MODE_DATA. Any other byte changes no state and makes `err` high for exactly the cycle after that byte.
- R2: In MODE_DATA, a byte is written to memory address `col + page*132` and `col` then increments by one. The scan port returns the byte at `scan_addr` one cycle after the address is presented.
- R3: In MODE_DATA with `col` at 132 or above, a byte is dropped. No memory cell changes, `col` holds and `redraw` is not set.
- R4: MODE_DATA lasts through any number of bytes until `rx_stop`. A stop returns any mode to MODE_IDLE. A byte presented in the same cycle as a stop is discarded.
- R5: After one command byte executes, the mode is MODE_IDLE again, so the next command needs a fresh 0x80.
- R6: Commands 0x00–0x0F replace `col[3:0]` with the command's low nibble. Commands 0x10–0x20 replace `col[7:4]` with the command's low nibble. 0x21 is unknown.
- R7: Commands 0xB0–0xBF load `page` with the command's bits [2:0].
- R8: Bit 0 of the command is the new flag value for these commands: 0xA0/0xA1 set `mirror`, 0xA4/0xA5 set `all_on`, 0xA6/0xA7 set `inverse`, and 0xAE/0xAF set `disp_enable`.
- R9: Commands 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB arm the skip flag. The next byte seen in MODE_CMD is then discarded. The skip flag survives stops and idle bytes. After the discarded byte the mode stays MODE_CMD.
- R10: Commands 0x40–0x7F leave `start_line` at 0. Commands 0xC0–0xC8 and 0xE3 change nothing. Every other command code pulses `err` and changes nothing.
- R11: Every stored data byte sets `redraw`. `redraw_ack` clears it, but a write in the same cycle wins over the clear.
- R12: `host_rd_data` is always 0xFF.
- R13: A scan read and a data write to the same address in the same cycle return the old byte. The new byte is seen one cycle later.
- R14: Reset clears `col`, `page`, all flags, `start_line`, `redraw`, `err`, the mode (to MODE_IDLE) and the skip flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One byte from the bus front end this cycle |
| rx_byte | input | 8 | Received byte |
| rx_stop | input | 1 | Bus stop condition strobe |
| redraw_ack | input | 1 | Scan-out clears the redraw flag |
| scan_addr | input | ADDR_W (11) | Scan-out read address |
| scan_data | output | 8 | Scan-out read data, one cycle latency |
| host_rd_data | output | 8 | Byte returned on host reads (constant 0xFF) |
| col | output | 8 | Column write pointer |
| page | output | PAGE_W (3) | Page write pointer |
| mirror | output | 1 | Horizontal mirror flag |
| all_on | output | 1 | Entire-display-on flag |
| inverse | output | 1 | Inverse video flag |
| disp_enable | output | 1 | Display enable flag |
| start_line | output | LINE_W (6) | Scan start line (held at 0) |
| redraw | output | 1 | Frame memory changed since last acknowledge |
| err | output | 1 | One-cycle pulse on a bad control byte or an unknown command |

## Verification
The write path is driven with bursts that start at different page/column origins and are read back at the computed addresses. One burst runs into the 132 edge, and a cell just past the edge is pre-filled so that a wrapped write would show. Command streams mix nibble pairs and page codes, including the out-of-range boundaries 0x20, 0x21 and 0xB8, so that a decoder which mis-slices fields or widens a range gives a different pointer. Parameter commands are followed by a stop, a new control byte and a flag command. This ordering tells apart a skip that is lost on stop, a skip tied to the mode, and a skip that fails to keep MODE_CMD afterwards.

// File: rtl/oled_dec_pkg.sv
package oled_dec_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_DATA = 2'd1,
        MODE_CMD  = 2'd2
    } mode_e;

    typedef enum logic [3:0] {
        CK_COL_LO,
        CK_COL_HI,
        CK_START,
        CK_PARAM,
        CK_MIRROR,
        CK_ALL_ON,
        CK_INVERSE,
        CK_ENABLE,
        CK_PAGE,
        CK_NOP,
        CK_BAD
    } cmd_kind_e;

    localparam logic [7:0] CTRL_CMD  = 8'h80;
    localparam logic [7:0] CTRL_DATA = 8'h40;

    // Sort a command byte into the action it requests.
    function automatic cmd_kind_e classify(input logic [7:0] c);
        cmd_kind_e k;
        if (c <= 8'h0F)                     k = CK_COL_LO;
        else if (c <= 8'h20)                k = CK_COL_HI;
        else if (c >= 8'h40 && c <= 8'h7F)  k = CK_START;
        else if (c >= 8'hB0 && c <= 8'hBF)  k = CK_PAGE;
        else if (c >= 8'hC0 && c <= 8'hC8)  k = CK_NOP;
        else begin
            case (c)
                8'hA0, 8'hA1: k = CK_MIRROR;
                8'hA4, 8'hA5: k = CK_ALL_ON;
                8'hA6, 8'hA7: k = CK_INVERSE;
                8'hAE, 8'hAF: k = CK_ENABLE;
                8'hE3:        k = CK_NOP;
                8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
                8'hD8, 8'hD9, 8'hDA, 8'hDB: k = CK_PARAM;
                default:      k = CK_BAD;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/oled_mode_fsm.sv
module oled_mode_fsm
    import oled_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic [7:0] in_byte,
    input  logic      in_stop,
    output mode_e     mode_o,
    output logic      skip_o,
    output logic      act_data,
    output logic      act_cmd,
    output cmd_kind_e kind_o,
    output logic      err_o
);

    mode_e     state_q, state_d;
    logic      skip_q, skip_d;
    logic      bad;
    cmd_kind_e kind;

    always_comb kind = classify(in_byte);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        skip_d  = skip_q;
        if (in_stop) begin
            state_d = MODE_IDLE;                  // ANY_TO_IDLE
        end else if (in_valid) begin
            unique case (state_q)
                MODE_IDLE: begin
                    if (in_byte == CTRL_CMD)       state_d = MODE_CMD;   // IDLE_TO_CMD
                    else if (in_byte == CTRL_DATA) state_d = MODE_DATA;  // IDLE_TO_DATA
                end
                MODE_DATA: begin
                    state_d = MODE_DATA;
                end
                MODE_CMD: begin
                    if (skip_q) begin
                        skip_d = 1'b0;                                   // CMD_HOLD
                    end else begin
                        state_d = MODE_IDLE;                             // CMD_TO_IDLE
                        if (kind == CK_PARAM) skip_d = 1'b1;
                    end
                end
                default: state_d = MODE_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_IDLE;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            skip_q  <= skip_d;
        end
    end

    // Per-byte actions.
    always_comb begin
        act_data = 1'b0;
        act_cmd  = 1'b0;
        bad      = 1'b0;
        if (in_valid && !in_stop) begin
            unique case (state_q)
                MODE_IDLE: bad = (in_byte != CTRL_CMD) && (in_byte != CTRL_DATA);
                MODE_DATA: act_data = 1'b1;
                MODE_CMD: begin
                    if (!skip_q) begin
                        act_cmd = 1'b1;
                        bad     = (kind == CK_BAD);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= bad;
    end

    assign mode_o = state_q;
    assign skip_o = skip_q;
    assign kind_o = kind;

endmodule

// File: rtl/oled_ctrl_regs.sv
module oled_ctrl_regs
    import oled_dec_pkg::*;
#(
    parameter int COLS   = 132,
    parameter int COL_W  = 8,
    parameter int PAGE_W = 3,
    parameter int ADDR_W = 11,
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_data,
    input  logic              act_cmd,
    input  cmd_kind_e         kind,
    input  logic [7:0]        in_byte,
    input  logic              redraw_ack,
    output logic [COL_W-1:0]  col_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              mirror_o,
    output logic              all_on_o,
    output logic              inverse_o,
    output logic              enable_o,
    output logic [LINE_W-1:0] start_o,
    output logic              redraw_o,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    localparam logic [COL_W-1:0]  COL_LIMIT = COL_W'(COLS);
    localparam logic [ADDR_W-1:0] PAGE_SPAN = ADDR_W'(COLS);

    logic [COL_W-1:0]  col_q;
    logic [PAGE_W-1:0] page_q;
    logic              mirror_q, all_on_q, inverse_q, enable_q, redraw_q;
    logic [LINE_W-1:0] start_q;

    assign wr_en   = act_data && (col_q < COL_LIMIT);
    assign wr_addr = ADDR_W'(col_q) + ADDR_W'(page_q) * PAGE_SPAN;
    assign wr_data = in_byte;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q     <= '0;
            page_q    <= '0;
            mirror_q  <= 1'b0;
            all_on_q  <= 1'b0;
            inverse_q <= 1'b0;
            enable_q  <= 1'b0;
            start_q   <= '0;
            redraw_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                col_q    <= col_q + COL_W'(1);
                redraw_q <= 1'b1;
            end else if (redraw_ack) begin
                redraw_q <= 1'b0;
            end
            if (act_cmd) begin
                unique case (kind)
                    CK_COL_LO:  col_q[3:0] <= in_byte[3:0];
                    CK_COL_HI:  col_q[7:4] <= in_byte[3:0];
                    CK_START:   start_q    <= '0;
                    CK_MIRROR:  mirror_q   <= in_byte[0];
                    CK_ALL_ON:  all_on_q   <= in_byte[0];
                    CK_INVERSE: inverse_q  <= in_byte[0];
                    CK_ENABLE:  enable_q   <= in_byte[0];
                    CK_PAGE:    page_q     <= in_byte[PAGE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign col_o     = col_q;
    assign page_o    = page_q;
    assign mirror_o  = mirror_q;
    assign all_on_o  = all_on_q;
    assign inverse_o = inverse_q;
    assign enable_o  = enable_q;
    assign start_o   = start_q;
    assign redraw_o  = redraw_q;

endmodule

// File: rtl/oled_frame_ram.sv
module oled_frame_ram #(
    parameter int DEPTH  = 1056,
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Read-before-write: the read samples the array before this edge's write lands.
    generate
        if (DEPTH == (1 << ADDR_W)) begin : g_full
            always_ff @(posedge clk) rd_q <= mem[rd_addr];
        end else begin : g_guard
            always_ff @(posedge clk) begin
                if (rd_addr < ADDR_W'(DEPTH)) rd_q <= mem[rd_addr];
                else                          rd_q <= '0;
            end
        end
    endgenerate

    assign rd_data = rd_q;

endmodule

// File: rtl/oled_cmd_decoder.sv
module oled_cmd_decoder
    import oled_dec_pkg::*;
#(
    parameter int COLS   = 132,
    parameter int PAGES  = 8,
    parameter int LINE_W = 6,
    localparam int DEPTH  = COLS * PAGES,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PAGE_W = $clog2(PAGES),
    localparam int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_stop,
    input  logic              redraw_ack,
    input  logic [ADDR_W-1:0] scan_addr,
    output logic [7:0]        scan_data,
    output logic [7:0]        host_rd_data,
    output logic [COL_W-1:0]  col,
    output logic [PAGE_W-1:0] page,
    output logic              mirror,
    output logic              all_on,
    output logic              inverse,
    output logic              disp_enable,
    output logic [LINE_W-1:0] start_line,
    output logic              redraw,
    output logic              err
);

    mode_e             mode_w;
    logic              skip_w;
    logic              act_data_w, act_cmd_w;
    cmd_kind_e         kind_w;
    logic              wr_en_w;
    logic [ADDR_W-1:0] wr_addr_w;
    logic [7:0]        wr_data_w;

    assign host_rd_data = 8'hFF;

    oled_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_byte  (rx_byte),
        .in_stop  (rx_stop),
        .mode_o   (mode_w),
        .skip_o   (skip_w),
        .act_data (act_data_w),
        .act_cmd  (act_cmd_w),
        .kind_o   (kind_w),
        .err_o    (err)
    );

    oled_ctrl_regs #(
        .COLS   (COLS),
        .COL_W  (COL_W),
        .PAGE_W (PAGE_W),
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_data   (act_data_w),
        .act_cmd    (act_cmd_w),
        .kind       (kind_w),
        .in_byte    (rx_byte),
        .redraw_ack (redraw_ack),
        .col_o      (col),
        .page_o     (page),
        .mirror_o   (mirror),
        .all_on_o   (all_on),
        .inverse_o  (inverse),
        .enable_o   (disp_enable),
        .start_o    (start_line),
        .redraw_o   (redraw),
        .wr_en      (wr_en_w),
        .wr_addr    (wr_addr_w),
        .wr_data    (wr_data_w)
    );

    oled_frame_ram #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) u_ram (
        .clk     (clk),
        .wr_en   (wr_en_w),
        .wr_addr (wr_addr_w),
        .wr_data (wr_data_w),
        .rd_addr (scan_addr),
        .rd_data (scan_data)
    );

endmodule

// File: rtl/oled_cmd_decoder_chk.sv
module oled_cmd_decoder_chk
    import oled_dec_pkg::*;
#(
    parameter int COLS   = 132,
    parameter int PAGE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [7:0]        rx_byte,
    input logic              rx_stop,
    input mode_e             mode,
    input logic              skip,
    input logic [7:0]        col,
    input logic [PAGE_W-1:0] page,
    input logic              mirror,
    input logic              inverse,
    input logic              redraw,
    input logic              err,
    input logic              wr_en
);

    logic take;
    assign take = rx_valid && !rx_stop;

    p_bad_ctrl_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE && take && rx_byte != 8'h80 && rx_byte != 8'h40) |=> err);

    p_enter_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE && take && rx_byte == 8'h80) |=> (mode == MODE_CMD));

    p_col_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DATA && take && col < 8'(COLS)) |=> (col == $past(col) + 8'd1));

    p_col_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DATA && take && col >= 8'(COLS)) |=> $stable(col));

    p_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stop |=> (mode == MODE_IDLE));

    p_cmd_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CMD && take && !skip) |=> (mode == MODE_IDLE));

    p_swallow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CMD && take && skip) |=>
            (mode == MODE_CMD && !skip && $stable(col) && $stable(page)
             && $stable(mirror) && $stable(inverse) && !err));

    p_redraw_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> redraw);

endmodule

bind oled_cmd_decoder oled_cmd_decoder_chk #(
    .COLS   (COLS),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_stop  (rx_stop),
    .mode     (mode_w),
    .skip     (skip_w),
    .col      (col),
    .page     (page),
    .mirror   (mirror),
    .inverse  (inverse),
    .redraw   (redraw),
    .err      (err),
    .wr_en    (wr_en_w)
);

// File: tb/sim_oled_cmd_decoder.sv
`timescale 1ns/1ps
module sim_oled_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_stop = 1'b0;
    logic        redraw_ack = 1'b0;
    logic [10:0] scan_addr = '0;
    logic [7:0]  scan_data, host_rd_data, col;
    logic [2:0]  page;
    logic        mirror, all_on, inverse, disp_enable, redraw, err;
    logic [5:0]  start_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    oled_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_stop(rx_stop), .redraw_ack(redraw_ack), .scan_addr(scan_addr),
        .scan_data(scan_data), .host_rd_data(host_rd_data), .col(col),
        .page(page), .mirror(mirror), .all_on(all_on), .inverse(inverse),
        .disp_enable(disp_enable), .start_line(start_line), .redraw(redraw),
        .err(err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h00;
    endtask

    task automatic cmd(input logic [7:0] b);
        send(8'h80); send(b);
    endtask

    task automatic stop();
        @(negedge clk); rx_stop = 1'b1;
        @(negedge clk); rx_stop = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); redraw_ack = 1'b1;
        @(negedge clk); redraw_ack = 1'b0;
    endtask

    task automatic set_col(input logic [7:0] c);
        cmd({4'h0, c[3:0]});
        cmd({4'h1, c[7:4]});
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk); scan_addr = 11'(a);
        @(negedge clk); v = scan_data;
    endtask

    task automatic t_reset();
        chk("R14 col", col, 0);      chk("R14 page", page, 0);
        chk("R14 mirror", mirror, 0); chk("R14 all_on", all_on, 0);
        chk("R14 inverse", inverse, 0); chk("R14 enable", disp_enable, 0);
        chk("R14 start", start_line, 0); chk("R14 redraw", redraw, 0);
        chk("R14 err", err, 0);
        cmd(8'hA1);   // skip flag cleared: first command executes
        chk("R14 skip clear", mirror, 1);
        cmd(8'hA0);
    endtask

    task automatic t_ctrl();
        stop();
        send(8'h33);
        chk("R1 bad ctrl err", err, 1);
        @(negedge clk);
        chk("R1 err single pulse", err, 0);
        send(8'h80); send(8'hA7);
        chk("R1 0x80 enters cmd", inverse, 1);
        chk("R1 no err", err, 0);
        cmd(8'hA6);
    endtask

    task automatic t_data();
        logic [7:0] v;
        stop();
        cmd(8'hB2); set_col(8'd5);
        send(8'h40); send(8'hAA); send(8'hBB); stop();
        chk("R2 col after burst", col, 7);
        chk("R2 page", page, 2);
        rd(269, v); chk("R2 mem 269", v, 8'hAA);
        rd(270, v); chk("R2 mem 270", v, 8'hBB);
    endtask

    task automatic t_limit();
        logic [7:0] v;
        stop();
        cmd(8'hB3); set_col(8'd0); send(8'h40); send(8'h5A); stop();
        cmd(8'hB2); set_col(8'd131); send(8'h40); send(8'h11);
        chk("R3 col reaches edge", col, 132);
        ack();
        send(8'h22);
        chk("R3 col holds", col, 132);
        chk("R3 no redraw", redraw, 0);
        stop();
        rd(395, v); chk("R3 last cell", v, 8'h11);
        rd(396, v); chk("R3 next page untouched", v, 8'h5A);
    endtask

    task automatic t_stop();
        stop();
        cmd(8'hB0); set_col(8'd10);
        send(8'h40); send(8'h01); send(8'h02);
        chk("R4 data mode persists", col, 12);
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h03; rx_stop = 1'b1;
        @(negedge clk); rx_valid = 1'b0; rx_stop = 1'b0;
        chk("R4 byte with stop dropped", col, 12);
        send(8'h03);
        chk("R4 idle after stop", err, 1);
        chk("R4 col after idle byte", col, 12);
        send(8'h80); stop(); send(8'h44);
        chk("R4 stop leaves cmd mode", err, 1);
    endtask

    task automatic t_once();
        stop();
        cmd(8'hA5);
        chk("R5 cmd executes", all_on, 1);
        send(8'hA4);
        chk("R5 second cmd needs 0x80 err", err, 1);
        chk("R5 second cmd ignored", all_on, 1);
        cmd(8'hA4);
    endtask

    task automatic t_col();
        stop();
        cmd(8'h0F); cmd(8'h1F);
        chk("R6 col FF", col, 8'hFF);
        cmd(8'h03); chk("R6 low nibble", col, 8'hF3);
        cmd(8'h20); chk("R6 0x20 high nibble", col, 8'h03);
        cmd(8'h1A); chk("R6 high nibble A", col, 8'hA3);
        cmd(8'h21);
        chk("R6 0x21 unknown err", err, 1);
        chk("R6 0x21 col kept", col, 8'hA3);
    endtask

    task automatic t_page();
        stop();
        cmd(8'hB5); chk("R7 page 5", page, 5);
        cmd(8'hBF); chk("R7 page BF", page, 7);
        cmd(8'hB8); chk("R7 page B8", page, 0);
    endtask

    task automatic t_flags();
        stop();
        cmd(8'hA1); chk("R8 mirror on", mirror, 1);
        cmd(8'hA5); chk("R8 all_on on", all_on, 1);
        cmd(8'hA7); chk("R8 inverse on", inverse, 1);
        cmd(8'hAF); chk("R8 enable on", disp_enable, 1);
        cmd(8'hA0); chk("R8 mirror off", mirror, 0);
        cmd(8'hA4); chk("R8 all_on off", all_on, 0);
        cmd(8'hA6); chk("R8 inverse off", inverse, 0);
        cmd(8'hAE); chk("R8 enable off", disp_enable, 0);
    endtask

    task automatic t_param();
        stop();
        cmd(8'h81); stop();
        send(8'h80); send(8'hA1);
        chk("R9 parameter swallowed", mirror, 0);
        chk("R9 no err on parameter", err, 0);
        send(8'hA1);
        chk("R9 cmd mode kept after skip", mirror, 1);
        cmd(8'hA0);
        cmd(8'hD9); send(8'h80); send(8'hA7); send(8'hA1);
        chk("R9 D9 swallows A7", inverse, 0);
        chk("R9 follow-on cmd", mirror, 1);
        cmd(8'hA0);
    endtask

    task automatic t_misc();
        logic [7:0] c0;
        logic [2:0] p0;
        stop();
        cmd(8'h7F);
        chk("R10 start line forced 0", start_line, 0);
        chk("R10 start no err", err, 0);
        c0 = col; p0 = page;
        cmd(8'hC4); chk("R10 C4 no err", err, 0);
        cmd(8'hE3); chk("R10 E3 no err", err, 0);
        chk("R10 nop col", col, c0); chk("R10 nop page", page, p0);
        cmd(8'hFF); chk("R10 unknown err", err, 1);
        chk("R10 unknown mirror", mirror, 0);
    endtask

    task automatic t_redraw();
        stop();
        cmd(8'hB1); set_col(8'd0); send(8'h40);
        ack(); chk("R11 ack clears", redraw, 0);
        send(8'h07); chk("R11 write sets", redraw, 1);
        ack();
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h09; redraw_ack = 1'b1;
        @(negedge clk); rx_valid = 1'b0; redraw_ack = 1'b0;
        chk("R11 write beats ack", redraw, 1);
        ack(); chk("R11 cleared again", redraw, 0);
        stop();
    endtask

    task automatic t_coll();
        stop();
        cmd(8'hB4); set_col(8'd20); send(8'h40); send(8'h10); stop();
        set_col(8'd20); send(8'h40);
        @(negedge clk); scan_addr = 11'd548; rx_valid = 1'b1; rx_byte = 8'h99;
        @(negedge clk); rx_valid = 1'b0;
        chk("R13 old data on collision", scan_data, 8'h10);
        @(negedge clk);
        chk("R13 new data next cycle", scan_data, 8'h99);
        stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_data();
        t_limit();
        t_stop();
        t_once();
        t_col();
        t_page();
        t_flags();
        t_param();
        t_misc();
        t_redraw();
        chk("R12 host read", host_rd_data, 8'hFF);
        t_coll();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule